// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Memory Banks

This block fetches one vector operand from a word-addressed main memory that is split into sixteen interleaved banks. Software-visible control is a single start pulse carrying a base word address, a stride and an element count. The engine walks the addresses base, base+stride, base+2*stride, and so on, with the address arithmetic wrapping modulo the address width. It issues at most one memory request per cycle and never reorders elements.

Each bank is occupied for four cycles once it accepts a request. The engine keeps a busy timer per bank and holds the current element back until its bank is free. Unit stride therefore streams at one element per cycle. A stride that is a multiple of the bank count sends every element to the same bank, which gives one element per four cycles. Read data comes back a fixed twelve cycles after its request. A tag pipeline of the same depth pairs each returning word with its element index and hands it straight to the vector register write port. A one-cycle completion pulse follows the final write.

Top module: `vld_strided_loader`

## Requirements
- R1: While reset is held and after it is released with no start, `busy`, `done`, `req_valid` and `wr_en` are all 0.
- R2: The request for element i carries the address `base_addr + i*stride` modulo 2^16. Elements are requested in ascending order, each exactly once, and at most one per cycle.
- R3: The bank of an address is its low 4 bits. No two requests to the same bank are issued less than 4 cycles apart.
- R4: Element i is requested in the first cycle that meets all of these conditions: it is at or after the cycle following start acceptance, it is after the cycle of element i-1's request, and its bank is free. A busy bank stalls issue, and no later element is requested ahead of it.
- R5: Every request causes exactly one write, with `wr_en` high exactly 12 cycles after the request cycle. In that cycle `wr_data` equals `rsp_data`.
- R6: Writes carry `wr_idx` values 0, 1, ..., n-1 in that order, one per element.
- R7: `done` is high for exactly one cycle, the cycle after the last write. `busy` is low in that cycle.
- R8: An element count of 0 gives `done` in the cycle after start, with no request and no write.
- R9: An element count above 64 is treated as 64.
- R10: A `start` pulse while `busy` is high is ignored. The running load continues with its original base, stride and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load; accepted only when idle |
| base_addr | input | 16 | Word address of element 0, sampled at start |
| stride | input | 16 | Word distance between elements, sampled at start, wraps modulo 2^16 |
| vec_len | input | 7 | Element count, sampled at start, clamped to 64 |
| rsp_data | input | 32 | Memory read data, valid 12 cycles after each request |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse when a load completes |
| req_valid | output | 1 | A memory read request is issued this cycle |
| req_addr | output | 16 | Word address of the request |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | 6 | Element index of the write |
| wr_data | output | 32 | Element value written |

## Verification
Unit stride, run over a full 64-element register, should stream with no stalls. If any request is delayed there, the bank timers are holding banks too long. Strides of 16 and 0 hit a single bank repeatedly, which pins the spacing at four cycles. Stride 8 alternates between two banks and shows whether issue waits correctly on the current element only. A stride of 4 from word 1 reproduces the classic 1, 5, 9 gather. Wrapping bases, a stride of all ones, a zero count, a count above 64 and a start pulse during a run isolate the modulo arithmetic, the immediate completion path, the clamp and the ignore-while-busy rule. Seeded random loads then mix all of these conditions. Each load is compared cycle by cycle against a schedule the bench derives from bank free times.

// File: rtl/vld_pkg.sv
`timescale 1ns/1ps
package vld_pkg;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;

  // Element count after applying the register length limit.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/vld_addr_gen.sv
`timescale 1ns/1ps
module vld_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_idx
);

  logic [ADDR_W-1:0] stride_q;

  // Next element address, modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a,
                                                  logic [ADDR_W-1:0] s);
    return a + s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_idx  <= '0;
      stride_q <= '0;
    end else if (load) begin
      cur_addr <= base;
      cur_idx  <= '0;
      stride_q <= stride;
    end else if (advance) begin
      cur_addr <= step_addr(cur_addr, stride_q);
      cur_idx  <= cur_idx + LEN_W'(1);
    end
  end

endmodule

// File: rtl/vld_bank_timer.sv
`timescale 1ns/1ps
module vld_bank_timer #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BUSY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 claim,
  input  logic [BANK_W-1:0]    claim_bank,
  output logic [NUM_BANKS-1:0] bank_free
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] remain;
    logic             hit;

    assign hit = claim && (claim_bank == BANK_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        remain <= '0;
      else if (hit)
        remain <= CNT_W'(BUSY - 1);
      else if (remain != '0)
        remain <= remain - CNT_W'(1);
    end

    assign bank_free[g] = (remain == '0);
  end

endmodule

// File: rtl/vld_return_pipe.sv
`timescale 1ns/1ps
module vld_return_pipe #(
  parameter int LAT   = 12,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx
);

  logic [LAT-1:0]            vld_q;
  logic [LAT-1:0][IDX_W-1:0] tag_q;

  if (LAT == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        tag_q <= '0;
      end else begin
        vld_q[0] <= push;
        tag_q[0] <= push_idx;
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        tag_q <= '0;
      end else begin
        vld_q <= {vld_q[LAT-2:0], push};
        tag_q <= {tag_q[LAT-2:0], push_idx};
      end
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_idx   = tag_q[LAT-1];

endmodule

// File: rtl/vld_strided_loader.sv
`timescale 1ns/1ps
module vld_strided_loader #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MEM_LAT   = 12,
  parameter int VLEN_MAX  = 64,
  localparam int LEN_W    = $clog2(VLEN_MAX + 1),
  localparam int IDX_W    = $clog2(VLEN_MAX),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  import vld_pkg::*;

  function automatic logic [BANK_W-1:0] bank_of(logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  ld_state_e          state_q;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   len_eff;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   cur_idx;
  logic [NUM_BANKS-1:0] bank_free;
  logic [BANK_W-1:0]  bank_sel;
  logic               pending;
  logic               start_acc;
  logic               issue_fire;
  logic               ret_fire;
  logic [IDX_W-1:0]   ret_idx;
  logic               last_ret;
  logic               empty_start;
  logic               done_q;

  assign len_eff     = LEN_W'(clamp_len(int'(vec_len), VLEN_MAX));
  assign start_acc   = start && (state_q == LD_IDLE);
  assign empty_start = start_acc && (len_eff == '0);

  vld_addr_gen #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_agen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_acc),
    .base    (base_addr),
    .stride  (stride),
    .advance (issue_fire),
    .cur_addr(cur_addr),
    .cur_idx (cur_idx)
  );

  assign pending    = (state_q == LD_RUN) && (cur_idx < len_q);
  assign bank_sel   = bank_of(cur_addr);
  assign issue_fire = pending && bank_free[bank_sel];

  vld_bank_timer #(
    .NUM_BANKS(NUM_BANKS),
    .BUSY     (BANK_BUSY)
  ) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim     (issue_fire),
    .claim_bank(bank_sel),
    .bank_free (bank_free)
  );

  vld_return_pipe #(
    .LAT  (MEM_LAT),
    .IDX_W(IDX_W)
  ) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (issue_fire),
    .push_idx (cur_idx[IDX_W-1:0]),
    .out_valid(ret_fire),
    .out_idx  (ret_idx)
  );

  assign last_ret = ret_fire && (LEN_W'(ret_idx) == (len_q - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= empty_start || last_ret;
      if (start_acc) begin
        len_q <= len_eff;
        if (len_eff != '0) state_q <= LD_RUN;
      end else if (last_ret) begin
        state_q <= LD_IDLE;
      end
    end
  end

  assign busy      = (state_q == LD_RUN);
  assign done      = done_q;
  assign req_valid = issue_fire;
  assign req_addr  = cur_addr;
  assign wr_en     = ret_fire;
  assign wr_idx    = ret_idx;
  assign wr_data   = rsp_data;

endmodule

// File: rtl/vld_loader_checker.sv
`timescale 1ns/1ps
module vld_loader_checker #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4,
  parameter int MEM_LAT   = 12,
  parameter int IDX_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CW       = $clog2(BANK_BUSY + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] stride,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx
);

  logic [CW-1:0]      shadow [NUM_BANKS];
  logic [MEM_LAT-1:0] iss_hist;
  logic [IDX_W-1:0]   wr_expect;
  logic [ADDR_W-1:0]  addr_expect;
  logic [ADDR_W-1:0]  stride_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) shadow[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (req_valid && req_addr[BANK_W-1:0] == BANK_W'(b))
          shadow[b] <= CW'(BANK_BUSY - 1);
        else if (shadow[b] != '0)
          shadow[b] <= shadow[b] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_hist    <= '0;
      wr_expect   <= '0;
      addr_expect <= '0;
      stride_l    <= '0;
    end else begin
      iss_hist <= {iss_hist[MEM_LAT-2:0], req_valid};
      if (start_acc) wr_expect <= '0;
      else if (wr_en) wr_expect <= wr_expect + IDX_W'(1);
      if (start_acc) begin
        addr_expect <= base_addr;
        stride_l    <= stride;
      end else if (req_valid) begin
        addr_expect <= addr_expect + stride_l;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R2
  addr_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr == addr_expect);

  // R3
  bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> shadow[req_addr[BANK_W-1:0]] == '0);

  // R5
  return_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == iss_hist[MEM_LAT-1]);

  // R6
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx == wr_expect) && busy);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind vld_strided_loader vld_loader_checker #(
  .ADDR_W   (ADDR_W),
  .NUM_BANKS(NUM_BANKS),
  .BANK_BUSY(BANK_BUSY),
  .MEM_LAT  (MEM_LAT),
  .IDX_W    (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_acc  (start_acc),
  .base_addr  (base_addr),
  .stride     (stride),
  .busy       (busy),
  .done       (done),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx)
);

// File: tb/vld_strided_loader_test.sv
`timescale 1ns/1ps
module vld_strided_loader_test;
  localparam int AW = 16, DW = 32, LAT = 12, BUSYC = 4, VMAX = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] stride = '0;
  logic [6:0]    vec_len = '0;
  logic [DW-1:0] rsp_data;
  logic          busy, done, req_valid, wr_en;
  logic [AW-1:0] req_addr;
  logic [5:0]    wr_idx;
  logic [DW-1:0] wr_data;

  vld_strided_loader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .vec_len(vec_len), .rsp_data(rsp_data),
    .busy(busy), .done(done), .req_valid(req_valid), .req_addr(req_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] memfn(logic [AW-1:0] a);
    return {a ^ 16'hC3A5, ~a};
  endfunction

  // fixed-latency memory model
  logic [AW-1:0] pa [LAT];
  logic          pv [LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= req_valid;
      pa[0] <= req_addr;
      for (int k = 1; k < LAT; k++) begin
        pv[k] <= pv[k-1];
        pa[k] <= pa[k-1];
      end
    end
  end
  assign rsp_data = pv[LAT-1] ? memfn(pa[LAT-1]) : '0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  task automatic check(bit ok, string req, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // monitor
  bit logging = 0;
  int nreq, nwr, ndone, done_c;
  bit done_busy;
  int req_c [128];
  int req_a [128];
  int wr_c [128];
  int wr_i [128];
  logic [DW-1:0] wr_d [128];
  always @(negedge clk) begin
    if (logging) begin
      if (req_valid && nreq < 128) begin
        req_c[nreq] = cyc; req_a[nreq] = int'(req_addr); nreq++;
      end
      if (wr_en && nwr < 128) begin
        wr_c[nwr] = cyc; wr_i[nwr] = int'(wr_idx); wr_d[nwr] = wr_data; nwr++;
      end
      if (done) begin
        done_c = cyc; ndone++; done_busy = busy;
      end
    end
  end

  int exp_iss [64];
  logic [AW-1:0] exp_a [64];

  task automatic run_vec(logic [AW-1:0] b, logic [AW-1:0] s, int len, bit interfere);
    int n, st, t, k, nf[16], exp_done;
    string tag;
    bit ok;
    int a_bad, c_bad;
    n = (len > VMAX) ? VMAX : len;
    for (int q = 0; q < 16; q++) nf[q] = 0;
    nreq = 0; nwr = 0; ndone = 0; done_c = -1; done_busy = 0;
    @(negedge clk);
    st = cyc;
    t = st + 1;
    for (int i = 0; i < n; i++) begin
      exp_a[i] = b + AW'(i) * s;
      if (nf[exp_a[i][3:0]] > t) t = nf[exp_a[i][3:0]];
      exp_iss[i] = t;
      nf[exp_a[i][3:0]] = t + BUSYC;
      t = t + 1;
    end
    exp_done = (n == 0) ? st + 1 : exp_iss[n-1] + LAT + 1;
    base_addr = b; stride = s; vec_len = 7'(len); start = 1'b1; logging = 1;
    @(negedge clk);
    start = 1'b0; base_addr = AW'($urandom); stride = AW'($urandom); vec_len = 7'($urandom);
    k = 0;
    while (ndone == 0 && k < 600) begin
      if (interfere && k == 4) start = 1'b1;
      if (interfere && k == 5) start = 1'b0;
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
    logging = 0;

    tag = (n == 0) ? "R8" : ((len > VMAX) ? "R9" : "R2");
    check(nreq == n, tag, $sformatf("request count actual=%0d expected=%0d", nreq, n));
    a_bad = -1; c_bad = -1;
    for (int i = 0; i < n && i < nreq; i++) begin
      if (a_bad < 0 && req_a[i] != int'(exp_a[i])) a_bad = i;
      if (c_bad < 0 && req_c[i] != exp_iss[i]) c_bad = i;
    end
    if (a_bad >= 0)
      check(0, interfere ? "R10" : "R2", $sformatf("elem %0d addr actual=%h expected=%h",
            a_bad, req_a[a_bad], exp_a[a_bad]));
    else
      check(1, interfere ? "R10" : "R2", "");
    if (c_bad >= 0)
      check(0, "R4", $sformatf("elem %0d issue cycle actual=%0d expected=%0d",
            c_bad, req_c[c_bad] - st, exp_iss[c_bad] - st));
    else
      check(1, "R4", "");
    // R3 spacing, measured directly from the observed requests
    ok = 1;
    for (int i = 0; i < nreq; i++)
      for (int j = i + 1; j < nreq; j++)
        if (req_a[i][3:0] == req_a[j][3:0] && req_c[j] - req_c[i] < BUSYC) ok = 0;
    check(ok, "R3", "same bank requested within 4 cycles actual=close expected=spaced");
    check(nwr == n, n == 0 ? "R8" : "R5", $sformatf("write count actual=%0d expected=%0d", nwr, n));
    ok = 1;
    for (int i = 0; i < n && i < nwr; i++)
      if (wr_c[i] != exp_iss[i] + LAT || wr_d[i] != memfn(exp_a[i])) begin
        if (ok) $display("FAIL R5: write %0d cycle/data actual=%0d/%h expected=%0d/%h", i,
                          wr_c[i] - st, wr_d[i], exp_iss[i] + LAT - st, memfn(exp_a[i]));
        ok = 0;
      end
    total++; if (!ok) bad++;
    ok = 1;
    for (int i = 0; i < nwr; i++) if (wr_i[i] != i) ok = 0;
    check(ok, "R6", $sformatf("write index order broken actual=%0d writes expected order 0..%0d", nwr, n - 1));
    check(ndone == 1 && done_c == exp_done && !done_busy, n == 0 ? "R8" : "R7",
          $sformatf("done pulses=%0d at=%0d busy=%0b expected 1 at=%0d busy=0",
                    ndone, done_c - st, done_busy, exp_done - st));
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7: watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    logic [AW-1:0] s;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check(!busy && !done && !req_valid && !wr_en, "R1",
          $sformatf("in reset actual=%b%b%b%b expected=0000", busy, done, req_valid, wr_en));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !req_valid && !wr_en, "R1",
          $sformatf("after reset actual=%b%b%b%b expected=0000", busy, done, req_valid, wr_en));

    run_vec(16'h0100, 16'd1, 64, 0);       // contiguous, no stalls
    run_vec(16'h0001, 16'd4, 16, 0);       // 1,5,9,... gather
    run_vec(16'h0020, 16'd16, 10, 0);      // one bank
    run_vec(16'h0007, 16'd0, 5, 0);        // same word repeated
    run_vec(16'h0003, 16'd8, 12, 0);       // two banks alternating
    run_vec(16'h1234, 16'd5, 0, 0);        // empty
    run_vec(16'h0040, 16'd3, 100, 0);      // clamped
    run_vec(16'hFFF0, 16'h0011, 30, 0);    // wraps
    run_vec(16'h0010, 16'hFFFF, 20, 0);    // descending
    run_vec(16'h0200, 16'd2, 20, 1);       // start while busy
    run_vec(16'h0300, 16'd1, 1, 0);        // single element

    for (int r = 0; r < 30; r++) begin
      case ($urandom % 4)
        0: s = AW'($urandom % 5);
        1: s = AW'(16 * ($urandom % 3));
        2: s = AW'($urandom % 40);
        default: s = AW'($urandom);
      endcase
      len = int'($urandom % 81);
      run_vec(AW'($urandom), s, len, (len > 8) && ($urandom % 3 == 0));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule